// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flag Update

This block is the combinational arithmetic and logic unit of an 8-bit accumulator-style processor. On each evaluation it takes an operation code, the accumulator, the two index registers, a data operand and the current status byte. It returns the result byte, the new status byte and a write-back strobe that says whether the result should be stored.

Instruction decode selects the operation and routes the operand. That operand is memory data or the accumulator for the shift, rotate, increment and decrement group. The caller stores the result: in the accumulator, in X for the AND-then-subtract operation, or in memory. Arithmetic is always binary. Register storage and BCD correction live outside the block.

The adder/subtractor is shared by add, subtract, the three compares, AND-then-subtract, increment and decrement. Shifts and rotates use a separate bit-steering path. A small flag unit merges carry, overflow, zero and negative into the incoming status byte.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0x0 (add) returns A + M + C; C takes bit 8 of the sum, V is set when A and M share a sign bit and the result's sign differs from A's; N and Z follow the result.
- R2: Operation code 0x1 (subtract) returns A - M - (1 - C); C is set when no borrow occurs, V is set when A's sign differs from both M's and the result's sign; N and Z follow the result.
- R3: Operation codes 0x2, 0x3 and 0x4 compare A, X or Y against M. result_o carries the low byte of the difference and wr_en_o is low. N and Z come from that byte, and C is set when the register is unsigned greater than or equal to M. V is unchanged.
- R4: Operation code 0x8 (bit test) sets Z when A AND M is zero and copies M bit 7 into N and M bit 6 into V. C is unchanged, result_o equals A and wr_en_o is low.
- R5: Operation code 0x9 shifts M left, moving bit 7 into C and filling bit 0 with zero. Code 0xA shifts M right, moving bit 0 into C and filling bit 7 with zero, so N is always clear. V is unchanged.
- R6: Operation code 0xB rotates M left, with the old C entering bit 0 and bit 7 moving to C. Code 0xC rotates M right, with the old C entering bit 7 and bit 0 moving to C. V is unchanged.
- R7: Operation code 0xF returns (A AND X) - M with wr_en_o high. N, Z and C follow the compare rule of R3 and V is unchanged.
- R8: Operation codes 0x5 (AND), 0x6 (OR), 0x7 (XOR), 0xD (increment M) and 0xE (decrement M) update only N and Z. C and V pass through unchanged, and increment and decrement wrap modulo 256.
- R9: In the status byte C is bit 0, Z bit 1, V bit 6 and N bit 7. Bits 5..2 always pass through unchanged. The decimal-mode bit (bit 3) has no effect, so add and subtract stay binary.
- R10: Whenever wr_en_o is high, Z equals (result_o == 0) and N equals result_o bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (encodings in R1-R8 tags) |
| acc_i | input | 8 | Accumulator value |
| idx_x_i | input | 8 | X index register value |
| idx_y_i | input | 8 | Y index register value |
| operand_i | input | 8 | Data operand M |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Result byte |
| status_o | output | 8 | Updated status byte |
| wr_en_o | output | 1 | High when the result is to be written back |

## Verification
Every operation runs with each of the 256 operands, with carry-in both clear and set, against eight accumulator values. These values include 0x00, 0x7F, 0x80 and 0xFF, so the signed-overflow edges, unsigned wrap and zero results all occur. The untouched status bits and the index registers are varied by a pattern derived from the operands. This separates a flag that is passed through from one that is recomputed, and it exposes any effect of the decimal bit. Directed vectors cover the hand-worked cases: positive plus positive overflowing negative, subtract with and without borrow, compare equal and compare below, bit test on disjoint bits, and shifts and rotates that produce zero.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int SW = 8;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 6;
  localparam int FLG_N = 7;

  typedef enum logic [3:0] {
    OP_ADC  = 4'h0,
    OP_SBC  = 4'h1,
    OP_CMPA = 4'h2,
    OP_CMPX = 4'h3,
    OP_CMPY = 4'h4,
    OP_AND  = 4'h5,
    OP_ORA  = 4'h6,
    OP_EOR  = 4'h7,
    OP_BIT  = 4'h8,
    OP_ASL  = 4'h9,
    OP_LSR  = 4'hA,
    OP_ROL  = 4'hB,
    OP_ROR  = 4'hC,
    OP_INC  = 4'hD,
    OP_DEC  = 4'hE,
    OP_AXS  = 4'hF
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  logic [DW:0] full;

  assign full   = {1'b0, lhs_i} + {1'b0, rhs_i} + {{DW{1'b0}}, cin_i};
  assign sum_o  = full[DW-1:0];
  assign cout_o = full[DW];
  // signed overflow: like-signed inputs, sum sign flipped
  assign ovf_o  = ~(lhs_i[DW-1] ^ rhs_i[DW-1]) & (lhs_i[DW-1] ^ full[DW-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] and_o
);
  assign and_o = a_i & m_i;

  always_comb begin
    unique case (op_i)
      OP_ORA:  res_o = a_i | m_i;
      OP_EOR:  res_o = a_i ^ m_i;
      default: res_o = a_i & m_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  logic          fill_lo;
  logic          fill_hi;
  logic          go_left;
  logic [DW-1:0] shl;
  logic [DW-1:0] shr;

  assign go_left = (op_i == OP_ASL) || (op_i == OP_ROL);
  assign fill_lo = (op_i == OP_ROL) ? cin_i : 1'b0;
  assign fill_hi = (op_i == OP_ROR) ? cin_i : 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign shl[i] = fill_lo;
    end else begin : g_mid_l
      assign shl[i] = m_i[i-1];
    end
    if (i == DW - 1) begin : g_hi
      assign shr[i] = fill_hi;
    end else begin : g_mid_r
      assign shr[i] = m_i[i+1];
    end
  end

  assign res_o  = go_left ? shl : shr;
  assign cout_o = go_left ? m_i[DW-1] : m_i[0];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] m_i,
  input  logic [DW-1:0] and_i,
  input  logic          add_cout_i,
  input  logic          add_ovf_i,
  input  logic          sh_cout_i,
  input  logic [SW-1:0] status_i,
  output logic [SW-1:0] status_o,
  output logic          wr_en_o
);
  always_comb begin
    status_o = status_i;
    wr_en_o  = 1'b1;
    unique case (op_i)
      OP_ADC, OP_SBC: begin
        status_o[FLG_C] = add_cout_i;
        status_o[FLG_V] = add_ovf_i;
      end
      OP_CMPA, OP_CMPX, OP_CMPY: begin
        status_o[FLG_C] = add_cout_i;
        wr_en_o         = 1'b0;
      end
      OP_AXS: status_o[FLG_C] = add_cout_i;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: status_o[FLG_C] = sh_cout_i;
      default: ;
    endcase

    if (op_i == OP_BIT) begin
      status_o[FLG_Z] = ~|and_i;
      status_o[FLG_N] = m_i[DW-1];
      status_o[FLG_V] = m_i[DW-2];
      wr_en_o         = 1'b0;
    end else begin
      status_o[FLG_Z] = ~|res_i;
      status_o[FLG_N] = res_i[DW-1];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] idx_x_i,
  input  logic [DW-1:0] idx_y_i,
  input  logic [DW-1:0] operand_i,
  input  logic [SW-1:0] status_i,
  output logic [DW-1:0] result_o,
  output logic [SW-1:0] status_o,
  output logic          wr_en_o
);
  alu_op_e       op;
  logic [DW-1:0] add_l, add_r, add_sum;
  logic          add_ci, add_co, add_ov;
  logic [DW-1:0] lg_res, lg_and;
  logic [DW-1:0] sh_res;
  logic          sh_co;
  logic          cin;

  assign op  = alu_op_e'(op_i);
  assign cin = status_i[FLG_C];

  // single adder serves all arithmetic; subtract is add of inverted operand
  always_comb begin
    add_l  = acc_i;
    add_r  = operand_i;
    add_ci = 1'b0;
    unique case (op)
      OP_ADC:  add_ci = cin;
      OP_SBC:  begin add_r = ~operand_i; add_ci = cin; end
      OP_CMPA: begin add_r = ~operand_i; add_ci = 1'b1; end
      OP_CMPX: begin add_l = idx_x_i; add_r = ~operand_i; add_ci = 1'b1; end
      OP_CMPY: begin add_l = idx_y_i; add_r = ~operand_i; add_ci = 1'b1; end
      OP_AXS:  begin add_l = acc_i & idx_x_i; add_r = ~operand_i; add_ci = 1'b1; end
      OP_INC:  begin add_l = operand_i; add_r = '0; add_ci = 1'b1; end
      OP_DEC:  begin add_l = operand_i; add_r = '1; end
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .lhs_i (add_l),
    .rhs_i (add_r),
    .cin_i (add_ci),
    .sum_o (add_sum),
    .cout_o(add_co),
    .ovf_o (add_ov)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op_i (op),
    .a_i  (acc_i),
    .m_i  (operand_i),
    .res_o(lg_res),
    .and_o(lg_and)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op_i  (op),
    .m_i   (operand_i),
    .cin_i (cin),
    .res_o (sh_res),
    .cout_o(sh_co)
  );

  always_comb begin
    unique case (op)
      OP_AND, OP_ORA, OP_EOR:         result_o = lg_res;
      OP_BIT:                         result_o = acc_i;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: result_o = sh_res;
      default:                        result_o = add_sum;
    endcase
  end

  alu8_flags #(.DW(DW), .SW(SW)) u_flags (
    .op_i      (op),
    .res_i     (result_o),
    .m_i       (operand_i),
    .and_i     (lg_and),
    .add_cout_i(add_co),
    .add_ovf_i (add_ov),
    .sh_cout_i (sh_co),
    .status_i  (status_i),
    .status_o  (status_o),
    .wr_en_o   (wr_en_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic [3:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] idx_x_i,
  input logic [DW-1:0] idx_y_i,
  input logic [DW-1:0] operand_i,
  input logic [SW-1:0] status_i,
  input logic [DW-1:0] result_o,
  input logic [SW-1:0] status_o,
  input logic          wr_en_o
);
  always_comb begin
    // R9
    keep_ctrl_bits_chk: assert (status_o[5:2] == status_i[5:2])
      else $error("control status bits altered");

    // R10
    if (wr_en_o) begin
      z_tracks_result_chk: assert (status_o[FLG_Z] == (result_o == '0)
                                   && status_o[FLG_N] == result_o[DW-1])
        else $error("N/Z disagree with written result");
    end

    // R3
    if (op_i == OP_CMPA || op_i == OP_CMPX || op_i == OP_CMPY) begin
      cmp_no_wb_chk: assert (!wr_en_o && status_o[FLG_V] == status_i[FLG_V])
        else $error("compare wrote back or touched V");
    end

    // R3
    if ((op_i == OP_CMPX && operand_i == idx_x_i) ||
        (op_i == OP_CMPY && operand_i == idx_y_i)) begin
      cmp_equal_chk: assert (status_o[FLG_Z] && status_o[FLG_C])
        else $error("equal compare lacks Z or C");
    end

    // R4
    if (op_i == OP_BIT) begin
      bit_copy_chk: assert (status_o[FLG_N] == operand_i[DW-1]
                            && status_o[FLG_V] == operand_i[DW-2]
                            && result_o == acc_i && !wr_en_o
                            && status_o[FLG_C] == status_i[FLG_C])
        else $error("bit test flags wrong");
    end

    // R5
    if (op_i == OP_LSR) begin
      lsr_n_clear_chk: assert (!status_o[FLG_N] && status_o[FLG_C] == operand_i[0])
        else $error("shift right flags wrong");
    end

    // R8
    if (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR ||
        op_i == OP_INC || op_i == OP_DEC) begin
      nz_only_chk: assert (status_o[FLG_C] == status_i[FLG_C]
                           && status_o[FLG_V] == status_i[FLG_V] && wr_en_o)
        else $error("logic/inc/dec touched C or V");
    end

    // R7
    if (op_i == OP_AXS) begin
      axs_v_keep_chk: assert (wr_en_o && status_o[FLG_V] == status_i[FLG_V])
        else $error("and-subtract V or write-back wrong");
    end
  end
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int NDIR       = 20;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a, x, y, m, p, res, pst;
    logic       wr;
  } vec_t;

  // op, a, x, y, m, p_in, res, p_out, wr
  localparam vec_t DIR [NDIR] = '{
    '{4'h0, 8'h50, 8'h00, 8'h00, 8'h50, 8'h20, 8'hA0, 8'hE0, 1'b1}, // R1 overflow
    '{4'h0, 8'hFF, 8'h00, 8'h00, 8'h01, 8'h21, 8'h01, 8'h21, 1'b1}, // R1 carry out
    '{4'h1, 8'h50, 8'h00, 8'h00, 8'hB0, 8'h21, 8'hA0, 8'hE0, 1'b1}, // R2 borrow+V
    '{4'h1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'hFF, 8'hA0, 1'b1}, // R2 borrow-in
    '{4'h3, 8'h00, 8'h10, 8'h00, 8'h10, 8'h60, 8'h00, 8'h63, 1'b0}, // R3 X equal
    '{4'h4, 8'h00, 8'h00, 8'h05, 8'h06, 8'h01, 8'hFF, 8'h80, 1'b0}, // R3 Y below
    '{4'h8, 8'h0F, 8'h00, 8'h00, 8'hC0, 8'h00, 8'h0F, 8'hC2, 1'b0}, // R4
    '{4'hA, 8'h00, 8'h00, 8'h00, 8'h01, 8'h80, 8'h00, 8'h03, 1'b1}, // R5 lsr
    '{4'hC, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h81, 1'b1}, // R6 ror
    '{4'hB, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h03, 1'b1}, // R6 rol
    '{4'h9, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h3C, 8'h80, 8'hBD, 1'b1}, // R5 asl
    '{4'hD, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h3D, 8'h00, 8'h3F, 1'b1}, // R8 inc wrap
    '{4'hE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h80, 1'b1}, // R8 dec wrap
    '{4'hF, 8'hF0, 8'h3C, 8'h00, 8'h31, 8'h40, 8'hFF, 8'hC0, 1'b1}, // R7
    '{4'h7, 8'hAA, 8'h00, 8'h00, 8'hAA, 8'h80, 8'h00, 8'h02, 1'b1}, // R8 xor
    '{4'h0, 8'h09, 8'h00, 8'h00, 8'h01, 8'h08, 8'h0A, 8'h08, 1'b1}, // R9 decimal ignored
    '{4'h2, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h40, 8'h01, 8'h41, 1'b0}, // R3 A above
    '{4'h5, 8'hF0, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h02, 1'b1}, // R8 and
    '{4'h6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h82, 8'h00, 8'h02, 1'b1}, // R8 or
    '{4'h1, 8'h80, 8'h00, 8'h00, 8'h01, 8'h21, 8'h7F, 8'h61, 1'b1}  // R2 V on neg-pos
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, idx_x_i = '0, idx_y_i = '0, operand_i = '0, status_i = '0;
  logic [7:0] result_o, status_o;
  logic       wr_en_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core dut_i (
    .op_i(op_i), .acc_i(acc_i), .idx_x_i(idx_x_i), .idx_y_i(idx_y_i),
    .operand_i(operand_i), .status_i(status_i),
    .result_o(result_o), .status_o(status_o), .wr_en_o(wr_en_o)
  );

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // returns {wr, res, status}
  function automatic logic [16:0] model(int op, int a, int x, int y, int m, int p);
    int  c = p & 1;
    int  r = 0;
    int  s;
    int  t;
    int  reg_v;
    bit  wr = 1'b1;
    bit  nz = 1'b1;
    int  st = p;
    case (op)
      0: begin
        r = a + m + c; s = sx(a) + sx(m) + c;
        st = (st & ~8'h41) | ((r > 255) ? 1 : 0) | ((s > 127 || s < -128) ? 8'h40 : 0);
      end
      1: begin
        r = a - m - (1 - c); s = sx(a) - sx(m) - (1 - c);
        st = (st & ~8'h41) | ((r >= 0) ? 1 : 0) | ((s > 127 || s < -128) ? 8'h40 : 0);
      end
      2, 3, 4: begin
        reg_v = (op == 2) ? a : (op == 3) ? x : y;
        r = reg_v - m; wr = 1'b0;
        st = (st & ~1) | ((reg_v >= m) ? 1 : 0);
      end
      5: r = a & m;
      6: r = a | m;
      7: r = a ^ m;
      8: begin
        r = a; wr = 1'b0; nz = 1'b0;
        st = (st & ~8'hC2) | (m & 8'hC0) | (((a & m) == 0) ? 2 : 0);
      end
      9:  begin r = m * 2;           st = (st & ~1) | (m / 128); end
      10: begin r = m / 2;           st = (st & ~1) | (m % 2);   end
      11: begin r = m * 2 + c;       st = (st & ~1) | (m / 128); end
      12: begin r = m / 2 + 128 * c; st = (st & ~1) | (m % 2);   end
      13: r = m + 1;
      14: r = m - 1;
      default: begin
        t = a & x; r = t - m;
        st = (st & ~1) | ((t >= m) ? 1 : 0);
      end
    endcase
    r = r & 255;
    if (nz) st = (st & ~8'h82) | ((r == 0) ? 2 : 0) | (r & 8'h80);
    return {wr, r[7:0], st[7:0]};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] a, x, y, m, p,
                       input logic [16:0] exp, input string tag);
    @(negedge clk);
    op_i = op; acc_i = a; idx_x_i = x; idx_y_i = y; operand_i = m; status_i = p;
    #(CLK_PERIOD/4);
    n_chk++;
    if ({wr_en_o, result_o, status_o} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h x=%h y=%h m=%h p=%h: got wr=%b res=%h st=%h, exp wr=%b res=%h st=%h",
               tag, op, a, x, y, m, p, wr_en_o, result_o, status_o,
               exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      8: return "R4";
      9, 10: return "R5";
      11, 12: return "R6";
      15: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (WDOG_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] avals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle inputs after reset: add of zeros gives zero with Z (R10, R1)
    apply(4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, {1'b1, 8'h00, 8'h02}, "R10 idle");

    for (int i = 0; i < NDIR; i++) begin
      apply(DIR[i].op, DIR[i].a, DIR[i].x, DIR[i].y, DIR[i].m, DIR[i].p,
            {DIR[i].wr, DIR[i].res, DIR[i].pst}, "directed");
    end

    // sweep: every op x 8 accumulators x 256 operands x carry in; R9 via varied status bits
    for (int op = 0; op < 16; op++) begin
      for (int ai = 0; ai < 8; ai++) begin
        for (int m = 0; m < 256; m++) begin
          for (int c = 0; c < 2; c++) begin
            int a = int'(avals[ai]);
            int x = (a ^ 8'h5A ^ m) & 255;
            int y = (m + ai * 37) & 255;
            int p = (((m * 7 + a) & 8'hFE) | c) & 255;
            if (m % 17 == 0) x = m;
            if (m % 19 == 0) y = m;
            apply(4'(op), 8'(a), 8'(x), 8'(y), 8'(m), 8'(p),
                  model(op, a, x, y, m, p), op_tag(op));
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule